// File: doc/BRIEF.md
# Multi-Channel Descriptor-Driven Block Copy Controller

This block is a small DMA control unit. Each channel's work is described by a four-word descriptor held in a shared SRAM. Software sets two base addresses. The first points at a table of starting descriptors, one per channel, packed by channel number. The second points at a table of the same shape where the controller keeps the live copy of each channel's descriptor. Per-channel enable and reset are reached indirectly. Software first writes a channel number into a selector register, then writes the channel control register, and the write acts on that channel only.

When an enabled channel sees a trigger, the controller reads its starting descriptor and checks the valid flag. An invalid descriptor stops the channel and raises an error flag. A valid descriptor is copied to the live table and then used to run a word-by-word block copy. After each beat the remaining count is written back to the live copy. When the count reaches zero the channel reports completion. Triggers from several channels are served one block at a time, lowest channel number first. One memory port carries all traffic: descriptor reads, live-copy writes, and data moves.

Top module: `dma_desc_ctrl`

## Requirements
- R1: While the global run bit (control register bit 0) is clear, no channel starts a transfer and the memory port stays idle. A trigger that arrives meanwhile on an enabled channel is kept and served once the run bit is set.
- R2: A write to the channel control register (address 4) changes only the channel whose number was last written to the selector (address 3). A read at address 4 returns that channel's state as bit 0 enable, bit 1 busy, bit 2 done, bit 3 fetch error.
- R3: A channel control write with bit 1 set resets the selected channel only if that channel is disabled, clearing its enable, done, error and pending state. If the channel is enabled, the whole write is ignored.
- R4: A control write with bit 1 set returns every register to its reset value, but only when both the run bit and the checksum-enable bit (control bit 2) are clear. Otherwise the write is ignored entirely.
- R5: A triggered channel n fetches its four descriptor words from descriptor base + 16·n + 4·k, with k = 0..3 in order. Word 0 is control (bit 0 valid, bits 9:8 beat size code), word 1 is the beat count, word 2 is the source end address and word 3 is the destination end address.
- R6: Before any data moves, the four fetched words are written in order to write-back base + 16·n + 4·k.
- R7: If the fetched control word has bit 0 clear, the channel sets its fetch-error flag and clears its enable and busy state. It then issues no write of any kind.
- R8: With a remaining count c, each beat reads source end − (c << size) and writes that word to destination end − (c << size). It then writes c−1 to write-back base + 16·n + 4. When the count is zero, the channel sets done and clears busy. A count of zero on fetch completes the channel after the write-back with no data move.
- R9: Pending channels are served one block at a time, lowest number first, and at most one channel is busy at any time.
- R10: Once raised, a memory request keeps its address and direction until the cycle in which ready is high.
- R11: After reset every readable register reads zero and no memory request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register index: 0 control, 1 descriptor base, 2 write-back base, 3 selector, 4 channel control |
| cfg_wdata | input | DW | Register write data |
| cfg_rdata | output | DW | Register read data for cfg_addr |
| trig | input | NCH | Per-channel transfer trigger, one bit per channel |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | DW | Memory byte address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid with ready |
| mem_rdy | input | 1 | Memory accepts the request this cycle |

## Verification
A three-beat copy is run under an irregular ready pattern. This separates correct address arithmetic and request holding from designs that only work with zero wait states. The sequence of count write-backs, 3, 2, 1, 0, distinguishes decrement-after-beat from an off-by-one. An invalid descriptor, a zero-count descriptor, and two channels triggered in the same cycle each have an observable signature: no writes, exactly four writes, and the order of descriptor fetches. The two reset interlocks are tried both blocked and allowed, so that an ignored write and an effective one are both seen at the register port.

// File: rtl/dma_desc_ctrl.sv
module dma_desc_ctrl #(
  parameter int NCH = 4,
  parameter int DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [2:0]     cfg_addr,
  input  logic [DW-1:0]  cfg_wdata,
  output logic [DW-1:0]  cfg_rdata,
  input  logic [NCH-1:0] trig,
  output logic           mem_req,
  output logic           mem_we,
  output logic [DW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  mem_rdata,
  input  logic           mem_rdy
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_WBD, S_RD, S_WR, S_WBC} st_t;

  st_t            st;
  logic           run, crc_en;
  logic [DW-1:0]  dbase, wbase, buf_q;
  logic [CW-1:0]  chsel, cur, pick;
  logic [NCH-1:0] en, pend, busy, done, err, cand;
  logic [1:0]     k;
  logic [DW-1:0]  dsc [4];
  logic [DW-1:0]  slot, step, koff;

  wire wr_ctrl  = cfg_we && (cfg_addr == 3'd0);
  wire wr_dbase = cfg_we && (cfg_addr == 3'd1);
  wire wr_wbase = cfg_we && (cfg_addr == 3'd2);
  wire wr_sel   = cfg_we && (cfg_addr == 3'd3);
  wire wr_ch    = cfg_we && (cfg_addr == 3'd4);
  wire grst     = wr_ctrl && cfg_wdata[1] && !run && !crc_en;
  wire hs       = mem_req && mem_rdy;
  wire last_k   = (k == 2'd3);

  assign cand = pend & en;
  assign slot = DW'(cur) << 4;
  assign koff = DW'({k, 2'b00});
  assign step = dsc[1] << dsc[0][9:8];

  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (cand[i]) pick = CW'(i);
  end

  assign mem_req = (st != S_IDLE);
  assign mem_we  = (st == S_WBD) || (st == S_WR) || (st == S_WBC);

  always_comb begin
    case (st)
      S_FETCH: mem_addr = dbase + slot + koff;
      S_WBD:   mem_addr = wbase + slot + koff;
      S_RD:    mem_addr = dsc[2] - step;
      S_WR:    mem_addr = dsc[3] - step;
      S_WBC:   mem_addr = wbase + slot + DW'(4);
      default: mem_addr = '0;
    endcase
    case (st)
      S_WBD:   mem_wdata = dsc[k];
      S_WR:    mem_wdata = buf_q;
      S_WBC:   mem_wdata = dsc[1];
      default: mem_wdata = '0;
    endcase
  end

  always_comb begin
    case (cfg_addr)
      3'd0:    cfg_rdata = DW'({crc_en, 1'b0, run});
      3'd1:    cfg_rdata = dbase;
      3'd2:    cfg_rdata = wbase;
      3'd3:    cfg_rdata = DW'(chsel);
      3'd4:    cfg_rdata = DW'({err[chsel], done[chsel], busy[chsel], en[chsel]});
      default: cfg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || grst) begin
      st <= S_IDLE; run <= 1'b0; crc_en <= 1'b0;
      dbase <= '0; wbase <= '0; buf_q <= '0;
      chsel <= '0; cur <= '0; k <= '0;
      en <= '0; pend <= '0; busy <= '0; done <= '0; err <= '0;
      for (int i = 0; i < 4; i++) dsc[i] <= '0;
    end else begin
      if (wr_ctrl && !cfg_wdata[1]) begin
        run    <= cfg_wdata[0];
        crc_en <= cfg_wdata[2];
      end
      if (wr_dbase) dbase <= cfg_wdata;
      if (wr_wbase) wbase <= cfg_wdata;
      if (wr_sel)   chsel <= cfg_wdata[CW-1:0];

      for (int i = 0; i < NCH; i++) begin
        if (trig[i] && en[i]) pend[i] <= 1'b1;
        else if (!en[i])      pend[i] <= 1'b0;
      end

      if (wr_ch) begin
        if (cfg_wdata[1]) begin
          if (!en[chsel]) begin
            en[chsel] <= 1'b0; done[chsel] <= 1'b0;
            err[chsel] <= 1'b0; pend[chsel] <= 1'b0;
          end
        end else begin
          en[chsel] <= cfg_wdata[0];
        end
      end

      case (st)
        S_IDLE: if (run && |cand) begin
          cur <= pick; k <= '0; st <= S_FETCH;
          pend[pick] <= 1'b0; busy[pick] <= 1'b1;
          done[pick] <= 1'b0; err[pick]  <= 1'b0;
        end
        S_FETCH: if (hs) begin
          dsc[k] <= mem_rdata;
          if (k == 2'd0 && !mem_rdata[0]) begin
            err[cur] <= 1'b1; en[cur] <= 1'b0; busy[cur] <= 1'b0;
            st <= S_IDLE;
          end else begin
            k <= k + 2'd1;
            if (last_k) st <= S_WBD;
          end
        end
        S_WBD: if (hs) begin
          k <= k + 2'd1;
          if (last_k) begin
            if (dsc[1] == '0) begin
              done[cur] <= 1'b1; busy[cur] <= 1'b0; st <= S_IDLE;
            end else st <= S_RD;
          end
        end
        S_RD: if (hs) begin
          buf_q <= mem_rdata; st <= S_WR;
        end
        S_WR: if (hs) begin
          dsc[1] <= dsc[1] - DW'(1); st <= S_WBC;
        end
        S_WBC: if (hs) begin
          if (dsc[1] == '0) begin
            done[cur] <= 1'b1; busy[cur] <= 1'b0; st <= S_IDLE;
          end else st <= S_RD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_SINGLE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(busy)); // R9

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy && !grst) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R10

  AST_BAD_DESC_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_FETCH && mem_rdy && k == 2'd0 && !mem_rdata[0] && !wr_ch)
    |=> (!en[cur] && err[cur] && !mem_req)); // R7

  AST_CHRST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ch && cfg_wdata[1] && en[chsel] && st != S_FETCH) |=> en[$past(chsel)]); // R3

  AST_GRST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && cfg_wdata[1] && (run || crc_en)) |=> ($stable(dbase) && $stable(wbase))); // R4
endmodule

// File: tb/dma_desc_ctrl_tb.sv
module dma_desc_ctrl_tb_top;
  localparam int NCH = 4;
  localparam int DW  = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0, cfg_rdata;
  logic [NCH-1:0] trig = '0;
  logic mem_req, mem_we, mem_rdy;
  logic [DW-1:0] mem_addr, mem_wdata, mem_rdata;

  logic [31:0] mem [256];
  int cyc = 0, stall = 0;
  int nreq = 0, nwr = 0, fn = 0, wn = 0;
  int flog [16];
  logic [31:0] wlog [16];
  logic [31:0] wbc_addr = 32'hFFFF_FFFF;
  int vec = 0, bad = 0;

  always #2 clk = ~clk;

  dma_desc_ctrl #(.NCH(NCH), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .trig(trig),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rdy(mem_rdy));

  assign mem_rdata = mem[mem_addr[9:2]];
  assign mem_rdy   = (stall != 0) ? ((cyc % 3) != 0) : 1'b1;

  always @(negedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (mem_req && mem_rdy) begin
      nreq++;
      if (mem_we) begin
        nwr++;
        mem[mem_addr[9:2]] <= mem_wdata;
        if (mem_addr == wbc_addr && wn < 16) begin wlog[wn] = mem_wdata; wn++; end
      end else if (mem_addr < 32'h40 && mem_addr[3:2] == 2'b00 && fn < 16) begin
        flog[fn] = int'(mem_addr[5:4]); fn++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); cfg_addr = a; #1 d = cfg_rdata;
  endtask

  task automatic pulse(input logic [NCH-1:0] t);
    @(negedge clk); trig = t;
    @(negedge clk); trig = '0;
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_ch(input int ch);
    logic [31:0] v;
    wr(3'd3, ch);
    for (int i = 0; i < 2000; i++) begin
      rd(3'd4, v);
      if (!v[1] && (v[2] || v[3])) break;
    end
  endtask

  task automatic put_desc(input int ch, input logic [31:0] c, input logic [31:0] n,
                          input logic [31:0] s, input logic [31:0] d);
    mem[ch*4] = c; mem[ch*4+1] = n; mem[ch*4+2] = s; mem[ch*4+3] = d;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); chk("R11 register after reset", v, 32'h0);
    end
    chk("R11 no request after reset", {31'b0, mem_req}, 32'h0);
  endtask

  task automatic t_select;
    logic [31:0] v;
    wr(3'd3, 2); wr(3'd4, 1);
    wr(3'd3, 1); rd(3'd4, v); chk("R2 unselected channel untouched", v, 32'h0);
    wr(3'd3, 2); rd(3'd4, v); chk("R2 selected channel enabled", v, 32'h1);
    wr(3'd4, 0);
  endtask

  task automatic t_copy;
    logic [31:0] v;
    int r0;
    put_desc(1, 32'h0000_0201, 3, 32'h20C, 32'h30C);
    for (int i = 0; i < 3; i++) begin mem[8'h80+i] = 32'hA000_0000 + i; mem[8'hC0+i] = 0; end
    wr(3'd1, 32'h000); wr(3'd2, 32'h100);
    wbc_addr = 32'h104 + 32'h10; wn = 0;
    wr(3'd3, 1); wr(3'd4, 1);
    r0 = nreq;
    pulse(4'b0010);
    repeat (20) @(negedge clk);
    chk("R1 no traffic while run bit clear", nreq - r0, 0);
    stall = 1;
    wr(3'd0, 1);
    wait_ch(1);
    stall = 0;
    rd(3'd4, v); chk("R8 done set busy clear", v, 32'h5);
    for (int i = 0; i < 3; i++) chk("R8 copied word", mem[8'hC0+i], 32'hA000_0000 + i);
    chk("R6 wb control", mem[8'h44], 32'h201);
    chk("R6 wb count final", mem[8'h45], 0);
    chk("R6 wb source", mem[8'h46], 32'h20C);
    chk("R6 wb dest", mem[8'h47], 32'h30C);
    chk("R8 count write-backs", wn, 4);
    for (int i = 0; i < 4; i++) chk("R8 count sequence", wlog[i], 3 - i);
  endtask

  task automatic t_invalid;
    logic [31:0] v;
    int w0;
    put_desc(2, 32'h0000_0200, 2, 32'h208, 32'h320);
    mem[8'hC6] = 32'hDEAD; mem[8'hC7] = 32'hDEAD;
    wr(3'd3, 2); wr(3'd4, 1);
    w0 = nwr;
    pulse(4'b0100);
    wait_ch(2);
    rd(3'd4, v); chk("R7 error set, enable cleared", v, 32'h8);
    chk("R7 no writes issued", nwr - w0, 0);
    chk("R7 destination untouched", mem[8'hC6], 32'hDEAD);
  endtask

  task automatic t_priority;
    logic [31:0] v;
    put_desc(0, 32'h201, 1, 32'h214, 32'h314);
    put_desc(3, 32'h201, 1, 32'h218, 32'h318);
    mem[8'h84] = 32'h1111_0000; mem[8'h85] = 32'h3333_0000;
    wr(3'd3, 0); wr(3'd4, 1); wr(3'd3, 3); wr(3'd4, 1);
    fn = 0;
    pulse(4'b1001);
    wait_ch(3); wait_ch(0);
    chk("R9 two fetches", fn, 2);
    chk("R5 first fetch channel 0", flog[0], 0);
    chk("R9 second fetch channel 3", flog[1], 3);
    chk("R9 ch0 data", mem[8'hC4], 32'h1111_0000);
    chk("R9 ch3 data", mem[8'hC5], 32'h3333_0000);
    rd(3'd4, v); chk("R9 ch0 done", v, 32'h5);
  endtask

  task automatic t_zero;
    logic [31:0] v;
    int w0, r0;
    put_desc(0, 32'h201, 0, 32'h214, 32'h314);
    mem[8'hC4] = 32'h0;
    w0 = nwr; r0 = nreq;
    pulse(4'b0001);
    wait_ch(0);
    rd(3'd4, v); chk("R8 zero count done", v, 32'h5);
    chk("R8 zero count only wb writes", nwr - w0, 4);
    chk("R8 zero count total requests", nreq - r0, 8);
    chk("R8 zero count no move", mem[8'hC4], 0);
  endtask

  task automatic t_chreset;
    logic [31:0] v;
    wr(3'd3, 1);
    wr(3'd4, 3); rd(3'd4, v); chk("R3 reset ignored while enabled", v, 32'h5);
    wr(3'd4, 0); rd(3'd4, v); chk("R3 disable keeps done", v, 32'h4);
    wr(3'd4, 2); rd(3'd4, v); chk("R3 reset clears channel", v, 32'h0);
  endtask

  task automatic t_greset;
    logic [31:0] v;
    wr(3'd1, 32'h40);
    wr(3'd0, 2); rd(3'd1, v); chk("R4 ignored while running", v, 32'h40);
    rd(3'd0, v); chk("R4 run bit kept", v, 32'h1);
    wr(3'd0, 4); wr(3'd0, 2); rd(3'd1, v); chk("R4 ignored with checksum on", v, 32'h40);
    wr(3'd0, 0); wr(3'd0, 2);
    rd(3'd1, v); chk("R4 base cleared", v, 0);
    rd(3'd2, v); chk("R4 wb base cleared", v, 0);
    wr(3'd3, 3); rd(3'd4, v); chk("R4 channel cleared", v, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset; t_select; t_copy; t_invalid; t_priority; t_zero; t_chreset; t_greset;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; vec++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule